// File: doc/BRIEF.md
# PHY Control Register Bank with Per-Bit Write Enables

This block holds the control words of a storage-interface PHY and a read-only status word behind a single-cycle memory-mapped strobe interface. Each write carries its own per-bit write enables, so software can change one field without reading the register first. Data bits 31:16 of a write are the enables for data bits 15:0. Only the stored bits whose enable is 1 take the new value.

The bank has seven 16-bit control words at byte offsets 0x00 through 0x18, in steps of four, and a status word at 0x20. Several fields are decoded straight onto output ports: DLL frequency select, drive impedance, power-up enable and DLL enable. Two completion flags from the analog side, calibration done and DLL ready, pass through a synchronizer and are returned in the status word. The reset input is asserted asynchronously and released synchronously inside the block. Every control bit resets to 0, so the PHY starts powered down, with the DLL off, the 200 MHz setting and 50 ohm drive.

Top module: `phy_ctrl_regbank`

## Requirements
- R1: On a write to a control word, stored bit x (0..15) takes wdata[x] only when wdata[x+16] is 1, and otherwise keeps its value. A write never changes another word.
- R2: rdata is registered. It carries the addressed value in the cycle after rd_en. Bits 31:16 always read 0. rdata is 0 in any cycle that does not follow an rd_en.
- R3: Word index is addr[5:2]. Indices 0..6 are control words. Index 8 (0x20) is the status word. Any other index, or any address with addr[1:0] not 0, reads as 0 and ignores writes.
- R4: The status word returns calibration done in bit 6 and DLL ready in bit 5, with all other bits 0. Writes to 0x20 change nothing.
- R5: After reset every control word reads 0. The outputs are pwr_up_o=0, dll_en_o=0, freq_sel_o=0 and drv_imp_o=0.
- R6: pwr_up_o is bit 0 of word 0x18 (1 = powered up). dll_en_o is bit 1 of the same word (1 = enabled). Both follow the cycle after the write.
- R7: drv_imp_o is bits 6:4 of word 0x18. drv_ohms_o maps codes 0,1,2,3,4 to 50,33,66,100,40 ohm. Codes 5..7 are stored and read back as written, but drv_imp_valid_o is 0 and drv_ohms_o is 0.
- R8: freq_sel_o is bits 13:12 of word 0x00. freq_mhz_o maps codes 0,1,2,3 to 200,50,100,150.
- R9: A read and a write to the same word in one cycle return the value held before that write.
- R10: The status flags pass through SYNC_STAGES flops. A flag held steady for SYNC_STAGES+1 cycles is reported by a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write enables [31:16] and data [15:0] |
| rdata | output | 32 | Registered read data |
| cal_done_i | input | 1 | Calibration complete flag (asynchronous) |
| dll_ready_i | input | 1 | DLL ready flag (asynchronous) |
| freq_sel_o | output | 2 | DLL frequency code |
| freq_mhz_o | output | 8 | Decoded DLL frequency in MHz |
| drv_imp_o | output | 3 | Drive impedance code |
| drv_imp_valid_o | output | 1 | Impedance code is defined |
| drv_ohms_o | output | 7 | Decoded impedance in ohm, 0 if undefined |
| pwr_up_o | output | 1 | Analog power-up enable |
| dll_en_o | output | 1 | DLL enable |

## Verification
The assertions take for granted that no strobe arrives during reset or while the internal reset release is still in progress. Under that condition, a decoded output can move only after a write to its own word. The bench holds both strobes low until several cycles after reset is released. The status flags change only in directed phases, and the bench then waits longer than the synchronizer depth before it reads. The random phase draws addresses over the full space, including unaligned and unmapped ones, and draws enables and data from $urandom with a fixed seed.

// File: rtl/phy_regbank_pkg.sv
package phy_regbank_pkg;
  localparam int HALF_W      = 16;
  localparam int CTRL_WORDS  = 7;
  localparam int STATUS_IDX  = 8;
  localparam int FREQ_IDX    = 0;
  localparam int PAD_IDX     = 6;
  localparam int PWR_BIT     = 0;
  localparam int DLLEN_BIT   = 1;
  localparam int IMP_LSB     = 4;
  localparam int FREQ_LSB    = 12;
  localparam int CAL_BIT     = 6;
  localparam int RDY_BIT     = 5;

  typedef logic [HALF_W-1:0] ctrl_word_t;

  typedef enum logic [2:0] {
    IMP_50  = 3'd0,
    IMP_33  = 3'd1,
    IMP_66  = 3'd2,
    IMP_100 = 3'd3,
    IMP_40  = 3'd4
  } imp_code_e;
endpackage

// File: rtl/regbank_rst_sync.sv
module regbank_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/regbank_flag_sync.sv
module regbank_flag_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];
  logic [WIDTH-1:0] pipe_d [STAGES];

  always_comb begin
    pipe_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) pipe_d[s] = pipe_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= pipe_d[s];
    end
  end

  assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/regbank_decode.sv
module regbank_decode #(
  parameter int ADDR_W     = 6,
  parameter int NWORDS     = 7,
  parameter int STAT_INDEX = 8
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NWORDS-1:0] wr_sel,
  output logic              rd_ctrl,
  output logic              rd_stat,
  output logic [ADDR_W-3:0] word_idx
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] LAST_CTRL = IDX_W'(NWORDS - 1);
  localparam logic [IDX_W-1:0] STAT_CODE = IDX_W'(STAT_INDEX);

  logic aligned;

  assign aligned  = (addr[1:0] == 2'b00);
  assign word_idx = addr[ADDR_W-1:2];

  for (genvar i = 0; i < NWORDS; i++) begin : g_wsel
    assign wr_sel[i] = wr_en && aligned && (word_idx == IDX_W'(i));
  end

  assign rd_ctrl = rd_en && aligned && (word_idx <= LAST_CTRL);
  assign rd_stat = rd_en && aligned && (word_idx == STAT_CODE);
endmodule

// File: rtl/regbank_word.sv
module regbank_word #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [WIDTH-1:0] data,
  input  logic [WIDTH-1:0] bit_en,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_next;

  always_comb begin
    q_next = (q & ~bit_en) | (data & bit_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= q_next;
  end
endmodule

// File: rtl/regbank_field_map.sv
module regbank_field_map
  import phy_regbank_pkg::*;
(
  input  ctrl_word_t  freq_word,
  input  ctrl_word_t  pad_word,
  output logic [1:0]  freq_sel_o,
  output logic [7:0]  freq_mhz_o,
  output logic [2:0]  drv_imp_o,
  output logic        drv_imp_valid_o,
  output logic [6:0]  drv_ohms_o,
  output logic        pwr_up_o,
  output logic        dll_en_o
);
  assign freq_sel_o = freq_word[FREQ_LSB+1:FREQ_LSB];
  assign drv_imp_o  = pad_word[IMP_LSB+2:IMP_LSB];
  assign pwr_up_o   = pad_word[PWR_BIT];
  assign dll_en_o   = pad_word[DLLEN_BIT];

  always_comb begin
    case (freq_sel_o)
      2'd0:    freq_mhz_o = 8'd200;
      2'd1:    freq_mhz_o = 8'd50;
      2'd2:    freq_mhz_o = 8'd100;
      default: freq_mhz_o = 8'd150;
    endcase
  end

  always_comb begin
    drv_imp_valid_o = 1'b1;
    case (drv_imp_o)
      IMP_50:  drv_ohms_o = 7'd50;
      IMP_33:  drv_ohms_o = 7'd33;
      IMP_66:  drv_ohms_o = 7'd66;
      IMP_100: drv_ohms_o = 7'd100;
      IMP_40:  drv_ohms_o = 7'd40;
      default: begin
        drv_ohms_o      = 7'd0;
        drv_imp_valid_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/phy_ctrl_regbank.sv
module phy_ctrl_regbank
  import phy_regbank_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              cal_done_i,
  input  logic              dll_ready_i,
  output logic [1:0]        freq_sel_o,
  output logic [7:0]        freq_mhz_o,
  output logic [2:0]        drv_imp_o,
  output logic              drv_imp_valid_o,
  output logic [6:0]        drv_ohms_o,
  output logic              pwr_up_o,
  output logic              dll_en_o
);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int DATA_W = 2 * HALF_W;

  logic                  rst_ns;
  logic [CTRL_WORDS-1:0] wr_sel;
  logic                  rd_ctrl;
  logic                  rd_stat;
  logic [IDX_W-1:0]      word_idx;
  ctrl_word_t            words [CTRL_WORDS];
  logic [1:0]            flags_s;
  logic [DATA_W-1:0]     rdata_next;

  regbank_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns)
  );

  regbank_decode #(
    .ADDR_W(ADDR_W), .NWORDS(CTRL_WORDS), .STAT_INDEX(STATUS_IDX)
  ) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_sel(wr_sel), .rd_ctrl(rd_ctrl), .rd_stat(rd_stat), .word_idx(word_idx)
  );

  for (genvar i = 0; i < CTRL_WORDS; i++) begin : g_word
    regbank_word #(.WIDTH(HALF_W)) u_word (
      .clk(clk), .rst_n(rst_ns), .we(wr_sel[i]),
      .data(wdata[HALF_W-1:0]), .bit_en(wdata[DATA_W-1:HALF_W]),
      .q(words[i])
    );
  end

  regbank_flag_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_ns),
    .async_i({cal_done_i, dll_ready_i}), .sync_o(flags_s)
  );

  always_comb begin
    rdata_next = '0;
    if (rd_ctrl) begin
      for (int i = 0; i < CTRL_WORDS; i++) begin
        if (word_idx == IDX_W'(i)) rdata_next[HALF_W-1:0] = words[i];
      end
    end else if (rd_stat) begin
      rdata_next[CAL_BIT] = flags_s[1];
      rdata_next[RDY_BIT] = flags_s[0];
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) rdata <= '0;
    else         rdata <= rdata_next;
  end

  regbank_field_map u_map (
    .freq_word(words[FREQ_IDX]), .pad_word(words[PAD_IDX]),
    .freq_sel_o(freq_sel_o), .freq_mhz_o(freq_mhz_o),
    .drv_imp_o(drv_imp_o), .drv_imp_valid_o(drv_imp_valid_o),
    .drv_ohms_o(drv_ohms_o), .pwr_up_o(pwr_up_o), .dll_en_o(dll_en_o)
  );
endmodule

// File: rtl/regbank_checker.sv
module regbank_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              cal_done_i,
  input logic              dll_ready_i,
  input logic [1:0]        freq_sel_o,
  input logic [7:0]        freq_mhz_o,
  input logic [2:0]        drv_imp_o,
  input logic              drv_imp_valid_o,
  input logic [6:0]        drv_ohms_o,
  input logic              pwr_up_o,
  input logic              dll_en_o
);
  localparam logic [ADDR_W-1:0] A_FREQ = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_PAD  = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h20);

  logic pad_wr, freq_wr, stat_wr;
  logic [13:0] outs;

  assign pad_wr  = wr_en && (addr == A_PAD);
  assign freq_wr = wr_en && (addr == A_FREQ);
  assign stat_wr = wr_en && (addr == A_STAT);
  assign outs    = {freq_sel_o, drv_imp_o, pwr_up_o, dll_en_o, drv_ohms_o};

  assert_hi_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[31:16] == 16'h0);

  assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rdata == 32'h0);

  assert_pad_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_wr |=> $stable({pwr_up_o, dll_en_o, drv_imp_o}));

  assert_pwr_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_wr && !wdata[16] && !wdata[17]) |=> $stable({pwr_up_o, dll_en_o}));

  assert_freq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_wr |=> $stable(freq_sel_o));

  assert_freq_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    freq_mhz_o != 8'd0);

  assert_imp_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drv_imp_valid_o == (drv_ohms_o != 7'd0));

  assert_status_ro_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> $stable(outs));

  assert_status_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_en) && $past(addr) == A_STAT) |-> (rdata[15:7] == 9'h0 && rdata[4:0] == 5'h0));

  assert_flag_known_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({cal_done_i, dll_ready_i}));
endmodule

bind phy_ctrl_regbank regbank_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/phy_ctrl_regbank_tb.sv
module phy_ctrl_regbank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cal_done_i = 1'b0;
  logic        dll_ready_i = 1'b0;
  logic [1:0]  freq_sel_o;
  logic [7:0]  freq_mhz_o;
  logic [2:0]  drv_imp_o;
  logic        drv_imp_valid_o;
  logic [6:0]  drv_ohms_o;
  logic        pwr_up_o;
  logic        dll_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] mdl [7];

  always #4 clk = ~clk;

  phy_ctrl_regbank u_dut (.*);

  function automatic logic [7:0] exp_mhz(input logic [1:0] c);
    case (c)
      2'd0: return 8'd200;
      2'd1: return 8'd50;
      2'd2: return 8'd100;
      default: return 8'd150;
    endcase
  endfunction

  function automatic logic [6:0] exp_ohms(input logic [2:0] c);
    case (c)
      3'd0: return 7'd50;
      3'd1: return 7'd33;
      3'd2: return 7'd66;
      3'd3: return 7'd100;
      3'd4: return 7'd40;
      default: return 7'd0;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [5:0] a);
    logic [3:0] idx = a[5:2];
    if (a[1:0] != 2'b00) return 32'h0;
    if (idx < 4'd7) return {16'h0, mdl[idx]};
    if (idx == 4'd8) return {25'h0, cal_done_i, dll_ready_i, 5'h0};
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [5:0] a, input logic [31:0] d);
    logic [3:0] idx = a[5:2];
    if (a[1:0] == 2'b00 && idx < 4'd7)
      mdl[idx] = (mdl[idx] & ~d[31:16]) | (d[15:0] & d[31:16]);
  endtask

  task automatic check_outs(input string tag);
    chk({tag, " R8 freq_sel"}, {30'h0, freq_sel_o}, {30'h0, mdl[0][13:12]});
    chk({tag, " R8 freq_mhz"}, {24'h0, freq_mhz_o}, {24'h0, exp_mhz(mdl[0][13:12])});
    chk({tag, " R6 pwr_up"}, {31'h0, pwr_up_o}, {31'h0, mdl[6][0]});
    chk({tag, " R6 dll_en"}, {31'h0, dll_en_o}, {31'h0, mdl[6][1]});
    chk({tag, " R7 imp"}, {29'h0, drv_imp_o}, {29'h0, mdl[6][6:4]});
    chk({tag, " R7 ohms"}, {25'h0, drv_ohms_o}, {25'h0, exp_ohms(mdl[6][6:4])});
    chk({tag, " R7 valid"}, {31'h0, drv_imp_valid_o}, {31'h0, (mdl[6][6:4] <= 3'd4)});
  endtask

  task automatic do_write(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_read(input logic [5:0] a, input string req);
    logic [31:0] e;
    rd_en = 1'b1; addr = a;
    e = exp_read(a);
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, rdata, e);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 7; i++) mdl[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R5 reset state
    check_outs("R5 reset");
    for (int i = 0; i < 7; i++) do_read(6'(i * 4), "R5 reset readback");
    chk("R2 idle rdata", rdata, 32'h0);

    // R1 masked write: set all of word 1, then only nibble 1 changes
    do_write(6'h04, 32'hFFFF_A5A5);
    do_read(6'h04, "R1 full write");
    do_write(6'h04, 32'h00F0_0000);
    do_read(6'h04, "R1 clear masked nibble");
    do_write(6'h04, 32'h0000_FFFF);
    do_read(6'h04, "R1 zero enables no change");

    // R6 power and DLL enable, independent masks
    do_write(6'h18, 32'h0001_0001);
    check_outs("R6 power only");
    do_write(6'h18, 32'h0002_0002);
    check_outs("R6 dll too");

    // R7 all impedance codes incl invalid 5..7
    for (int c = 0; c < 8; c++) begin
      do_write(6'h18, 32'h0070_0000 | (32'(c) << 4));
      check_outs("R7 code");
      do_read(6'h18, "R7 stored as written");
    end

    // R8 all frequency codes
    for (int c = 0; c < 4; c++) begin
      do_write(6'h00, 32'h3000_0000 | (32'(c) << 12));
      check_outs("R8 code");
    end

    // R4 status read and read-only
    cal_done_i = 1'b1; dll_ready_i = 1'b0;
    repeat (4) @(negedge clk);
    do_read(6'h20, "R10 cal flag");
    cal_done_i = 1'b0; dll_ready_i = 1'b1;
    repeat (4) @(negedge clk);
    do_read(6'h20, "R10 rdy flag");
    cal_done_i = 1'b1;
    repeat (4) @(negedge clk);
    do_write(6'h20, 32'hFFFF_FFFF);
    do_read(6'h20, "R4 status after write");
    for (int i = 0; i < 7; i++) do_read(6'(i * 4), "R4 words untouched");
    check_outs("R4 outputs untouched");

    // R3 unmapped, unaligned
    do_write(6'h1C, 32'hFFFF_FFFF);
    do_write(6'h19, 32'hFFFF_FFFF);
    do_write(6'h3C, 32'hFFFF_FFFF);
    do_read(6'h1C, "R3 unmapped 0x1C");
    do_read(6'h19, "R3 unaligned");
    do_read(6'h24, "R3 unmapped 0x24");
    for (int i = 0; i < 7; i++) do_read(6'(i * 4), "R3 words untouched");

    // R9 read and write same cycle
    begin
      logic [31:0] old;
      old = exp_read(6'h08);
      wr_en = 1'b1; rd_en = 1'b1; addr = 6'h08; wdata = 32'hFFFF_1234;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      model_write(6'h08, 32'hFFFF_1234);
      chk("R9 read returns old value", rdata, old);
      do_read(6'h08, "R9 new value after");
    end

    // random phase: R1 R2 R3
    for (int n = 0; n < 600; n++) begin
      logic [5:0] a;
      logic [31:0] d;
      a = ($urandom % 4 == 0) ? 6'($urandom) : 6'(($urandom % 10) * 4);
      d = $urandom;
      if ($urandom % 2 == 1) begin
        do_write(a, d);
        check_outs("R1 random");
      end else begin
        do_read(a, "R2 random read");
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule